// File: doc/BRIEF.md
# Daisy-Chainable Oversampled SPI Slave

This block is the serial configuration port of a peripheral. A host drives a four-wire SPI link in mode 0 (clock idles low). The block runs wholly in a fast system clock domain. The chip-select, clock and data pins each pass through a two-flop synchronizer and then through a glitch filter. Edges on the serial clock are found by comparing the filtered level with its value one system cycle earlier, so the serial clock may run at no more than half the system clock rate.

While selected, the block shifts received bits through a 20-bit register, most significant bit first. When chip-select goes low, the register is loaded with a status word from the host logic, so the first 20 bits returned are readback data. Any further bits fall out of the top of the register and reach the output pin 20 serial clocks after they came in. Several devices can therefore be chained on one select line. When chip-select returns high, the last 20 bits received become the new command and a one-cycle strobe marks it. A transfer that ended early is discarded. The block does not interpret the command bits.

The controller has three states. IDLE waits with the data output low and the bit count at zero. Seeing chip-select low, IDLE moves to ACTIVE (select), loading the status word. ACTIVE shifts on every filtered rising clock edge and drives the output after every falling edge. Seeing chip-select high, ACTIVE moves to COMMIT (deselect). COMMIT spends one cycle deciding whether the command is complete, then always moves back to IDLE (retire).

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, `cmd_valid` is 0, `cmd_word` is all zeros and `sdo` is 0.
- R2: A transfer of exactly 20 serial clocks sets `cmd_word` to the received bits, with the first bit sent at bit 19 and the last at bit 0.
- R3: A transfer of more than 20 serial clocks sets `cmd_word` to the final 20 bits received before chip-select rose, and earlier bits are dropped.
- R4: With more than 20 clocks, the bit taken in at serial clock k appears on `sdo` after the falling edge of clock k+19, so the host samples it at the rising edge of clock k+20.
- R5: When chip-select falls, `status_word` is captured. `sdo` then presents it bit 19 first: bit 19 before the first rising clock edge, and each following bit after each falling edge.
- R6: Each completed transfer raises `cmd_valid` for exactly one system cycle, a few cycles after chip-select rises. It is never raised while chip-select is low.
- R7: A transfer with fewer than 20 rising clock edges raises no `cmd_valid` and leaves `cmd_word` at its previous value.
- R8: While deselected, `sdo` is held low and the bit count is zero, so each transfer starts fresh.
- R9: A pulse shorter than `FILT_CYCLES` system cycles on chip-select, serial clock or data causes no edge. This holds whether the link is idle or mid-transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least twice the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Serial clock from the host, unsynchronized |
| sdi_pin | input | 1 | Serial data from the host, unsynchronized |
| csn_pin | input | 1 | Chip-select, active low, unsynchronized |
| status_word | input | 20 | Readback word, loaded when chip-select falls |
| sdo | output | 1 | Serial data to the host or to the next device in the chain |
| cmd_word | output | 20 | Last committed command |
| cmd_valid | output | 1 | One-cycle strobe marking a new command |

## Verification
Several properties are checked by the assertions on every cycle. Each filtered pin level changes only after its hold count is full. A bit taken in on a rising clock edge lands in bit 0 of the shift register. While deselected, the count is zero and the output is low. The strobe lasts one cycle and follows only the commit state. The command word never changes without the strobe. Whole-transfer behaviour can only be shown by the bench scenarios. These cover status readback order, the 20-clock pass-through delay in a three-device chain, the commit of only the final 20 bits, rejection of short transfers, and glitches on each pin that leave the result untouched.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    localparam int unsigned FRAME_BITS = 20;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } link_state_e;

endpackage

// File: rtl/spi_pin_filter.sv
module spi_pin_filter #(
    parameter int unsigned FILT_CYCLES = 2,
    parameter logic        RESET_VAL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    localparam int unsigned CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RESET_VAL}};
            hold_q <= '0;
            level  <= RESET_VAL;
        end else begin
            sync_q <= {sync_q[0], pin};
            if (sync_q[1] == level) begin
                hold_q <= '0;
            end else if (hold_q == LAST) begin
                level  <= sync_q[1];
                hold_q <= '0;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    // R9: the filtered level moves only after a full run of differing samples
    assert_filter_min_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> ($past(hold_q) == LAST));

endmodule

// File: rtl/spi_chain_core.sv
module spi_chain_core
    import spi_chain_pkg::*;
#(
    parameter int unsigned WIDTH = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_f,
    input  logic             sdi_f,
    input  logic             csn_f,
    input  logic [WIDTH-1:0] status_word,
    output logic             sdo,
    output logic [WIDTH-1:0] cmd_word,
    output logic             cmd_valid
);
    localparam int unsigned CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

    link_state_e      state_q, state_d;
    logic             sck_prev_q;
    logic [WIDTH-1:0] shreg_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             sck_rise, sck_fall;

    assign sck_rise = sck_f & ~sck_prev_q;
    assign sck_fall = ~sck_f & sck_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: select, deselect, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!csn_f) state_d = ST_ACTIVE;
            ST_ACTIVE: if (csn_f)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            sdo        <= 1'b0;
            cmd_word   <= '0;
            cmd_valid  <= 1'b0;
        end else begin
            sck_prev_q <= sck_f;
            cmd_valid  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q <= '0;
                    if (!csn_f) begin
                        shreg_q <= status_word;
                        sdo     <= status_word[WIDTH-1];
                    end else begin
                        sdo     <= 1'b0;
                    end
                end
                ST_ACTIVE: begin
                    if (!csn_f) begin
                        if (sck_rise) begin
                            shreg_q <= {shreg_q[WIDTH-2:0], sdi_f};
                            if (bit_cnt_q != FULL) bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (sck_fall) sdo <= shreg_q[WIDTH-1];
                    end
                end
                ST_COMMIT: begin
                    if (bit_cnt_q == FULL) begin
                        cmd_word  <= shreg_q;
                        cmd_valid <= 1'b1;
                    end
                    bit_cnt_q <= '0;
                    sdo       <= 1'b0;
                end
                default: begin
                    bit_cnt_q <= '0;
                    sdo       <= 1'b0;
                end
            endcase
        end
    end

    // R2: a rising serial clock edge while selected brings the data bit into bit 0
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !csn_f && sck_rise) |=> (shreg_q[0] == $past(sdi_f)));

    // R6: the strobe lasts one cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: the strobe only follows the commit state
    assert_valid_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(state_q) == ST_COMMIT));

    // R7: the command word changes only together with the strobe
    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_word));

    // R8: the count is zero while deselected
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (bit_cnt_q == '0));

    // R8: the output stays low through a deselected stretch
    assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !sdo);

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int unsigned WIDTH       = FRAME_BITS,
    parameter int unsigned FILT_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_pin,
    input  logic             sdi_pin,
    input  logic             csn_pin,
    input  logic [WIDTH-1:0] status_word,
    output logic             sdo,
    output logic [WIDTH-1:0] cmd_word,
    output logic             cmd_valid
);
    localparam int unsigned NPINS = 3;
    localparam logic [NPINS-1:0] PIN_RESET = 3'b100; // {csn, sdi, sck}

    logic [NPINS-1:0] raw_pins;
    logic [NPINS-1:0] filt_pins;

    assign raw_pins = {csn_pin, sdi_pin, sck_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        spi_pin_filter #(
            .FILT_CYCLES (FILT_CYCLES),
            .RESET_VAL   (PIN_RESET[g])
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (raw_pins[g]),
            .level (filt_pins[g])
        );
    end

    spi_chain_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_f       (filt_pins[0]),
        .sdi_f       (filt_pins[1]),
        .csn_f       (filt_pins[2]),
        .status_word (status_word),
        .sdo         (sdo),
        .cmd_word    (cmd_word),
        .cmd_valid   (cmd_valid)
    );

endmodule

// File: tb/test_spi_chain_slave.sv
module test_spi_chain_slave;

    localparam int HALF = 10; // system cycles per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_pin = 1'b0;
    logic        sdi_pin = 1'b0;
    logic        csn_pin = 1'b1;
    logic [19:0] status_word = '0;
    logic        sdo;
    logic [19:0] cmd_word;
    logic        cmd_valid;

    always #5 clk = ~clk;

    spi_chain_slave i_spi_chain_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_pin     (sck_pin),
        .sdi_pin     (sdi_pin),
        .csn_pin     (csn_pin),
        .status_word (status_word),
        .sdo         (sdo),
        .cmd_word    (cmd_word),
        .cmd_valid   (cmd_valid)
    );

    typedef struct {
        logic [19:0] cmd;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          failures = 0;
    int          strobes = 0;
    logic        prev_valid = 1'b0;
    logic [19:0] last_cmd = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop and compare each committed command
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                strobes++;
                if (prev_valid) check(1'b0, "R6 strobe longer than one cycle", 64'd1, 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected strobe", 64'(cmd_word), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cmd_word == e.cmd, e.tag, 64'(cmd_word), 64'(e.cmd));
                end
            end
            prev_valid <= cmd_valid;
        end
    end

    task automatic pulse_glitch(input int which);
        @(negedge clk);
        if (which == 0) sck_pin = ~sck_pin; else csn_pin = ~csn_pin;
        @(negedge clk);
        if (which == 0) sck_pin = ~sck_pin; else csn_pin = ~csn_pin;
    endtask

    // driver: one transfer of n bits, data sent from bit n-1 down
    task automatic xfer(input int n, input logic [63:0] data, input logic [19:0] stat,
                        input bit g_sck, input bit g_csn);
        logic [63:0] got;
        logic [63:0] expv;
        int          seen;
        got  = '0;
        expv = '0;
        seen = strobes;
        @(negedge clk);
        status_word = stat;
        if (n >= 20) begin
            exp_t e;
            e.cmd = data[19:0];
            e.tag = (n > 20) ? "R3 last 20 bits" : "R2 command word";
            exp_q.push_back(e);
            last_cmd = data[19:0];
        end
        csn_pin = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi_pin = data[n-1-i];
            repeat (3) @(negedge clk);
            if (i == 5 && g_sck) pulse_glitch(0);
            else if (i == 7 && g_csn) pulse_glitch(1);
            else repeat (2) @(negedge clk);
            repeat (HALF - 5) @(negedge clk);
            got[i] = sdo;
            sck_pin = 1'b1;
            repeat (HALF) @(negedge clk);
            sck_pin = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn_pin = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        for (int i = 0; i < n; i++)
            expv[i] = (i < 20) ? stat[19-i] : data[n-1-(i-20)];
        check(got == expv, (n > 20) ? "R4 pass-through on sdo" : "R5 status readback",
              got, expv);
        if (n >= 20) begin
            check(exp_q.size() == 0 && strobes == seen + 1, "R6 one strobe per transfer",
                  64'(strobes - seen), 64'd1);
        end else begin
            check(strobes == seen, "R7 no strobe for short transfer", 64'(strobes - seen), 64'd0);
            check(cmd_word == last_cmd, "R7 command kept", 64'(cmd_word), 64'(last_cmd));
        end
        check(sdo == 1'b0, "R8 sdo low when deselected", 64'(sdo), 64'd0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cmd_valid == 1'b0, "R1 cmd_valid after reset", 64'(cmd_valid), 64'd0);
        check(cmd_word == '0, "R1 cmd_word after reset", 64'(cmd_word), 64'd0);
        check(sdo == 1'b0, "R1 sdo after reset", 64'(sdo), 64'd0);

        // R2 R5 plain 20-bit transfers
        xfer(20, 64'hA5C3E, 20'h9F00D, 1'b0, 1'b0);
        xfer(20, 64'h0F1F0, 20'h5AAAA, 1'b0, 1'b0);
        // R3 R4 longer transfer
        xfer(32, 64'hDEAD_BEEF, 20'h12345, 1'b0, 1'b0);
        // R7 short transfer
        xfer(12, 64'hABC, 20'hFFFFF, 1'b0, 1'b0);
        // R8 fresh start after a short transfer
        xfer(20, 64'h80001, 20'h00001, 1'b0, 1'b0);
        // R4 three-device chain
        xfer(60, 64'h0FED_CBA9_8765_4321, 20'hC0FFE, 1'b0, 1'b0);
        // R9 glitches mid-transfer on the serial clock and on chip-select
        xfer(20, 64'h3C3C3, 20'h0A0A0, 1'b1, 1'b0);
        xfer(20, 64'hC3C3C, 20'h50505, 1'b0, 1'b1);
        // R9 chip-select glitch while idle
        begin
            int seen;
            seen = strobes;
            status_word = 20'hFFFFF;
            pulse_glitch(1);
            repeat (20) @(negedge clk);
            check(sdo == 1'b0, "R9 idle select glitch sdo", 64'(sdo), 64'd0);
            check(strobes == seen, "R9 idle select glitch strobe", 64'(strobes - seen), 64'd0);
        end
        xfer(20, 64'h7E7E7, 20'h81818, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule